// File: doc/BRIEF.md
# Serial Fixed-Point FIR Multiply-Accumulate

This block computes one output of an N-tap FIR filter in signed fractional fixed-point arithmetic. A single multiplier and a single accumulator register are shared across all taps, and a down-counter walks the taps one per clock. This spends cycles to save area: a result takes N steps instead of one.

A caller offers a new input word on `x_in` and raises `start`. The request is honoured only once `start` has been released. The block then shifts the word into its tap history and runs the multiply-accumulate over all taps. It publishes the sum on `y` and pulses `finished` for one clock. `y` keeps that value until the next computation completes. The coefficients are constants computed from parameters at elaboration time.

Top module: `fir_serial_mac`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, `y` reads 0 and `finished` reads 0 after that edge. Reset also empties the tap history, so the next result depends only on words accepted after reset.
- R2: The coefficient of tap i (0 ≤ i < TAPS) is C_STEP·(i+1) − (C_STEP·TAPS)/2, taken as a signed COEF-width value. With the defaults (TAPS=8, C_STEP=1000) this gives −3000 up to 4000.
- R3: `y` equals the sum over i of (h[i]·c[i]) shifted left by one bit, with all arithmetic modulo 2^(2·WIDTH). Here h[0] is the newest accepted word and h[i] the word accepted i requests earlier. The shift drops the product's top bit and appends a zero.
- R4: The block leaves its idle state only when `start` is sampled low at an edge after being sampled high in idle. While `start` stays high, no computation begins and `finished` stays 0.
- R5: If `start` is first sampled low at edge k, `finished` is high right after edge k+TAPS+1. That is the (TAPS+2)-th edge counting edge k. The tap counter stays within 0..TAPS−1 and moves only while taps are being processed.
- R6: `finished` is high for exactly one clock per computation.
- R7: `y` changes only at the edge that raises `finished`, or under reset.
- R8: `start` pulses that begin and end while a computation is running are ignored. No extra `finished` pulse follows, and `y` is unchanged.
- R9: Each accepted request shifts exactly one word into the history. Older words move one position up, and the word in position TAPS−1 is discarded.
- R10: Asserting reset during a computation abandons it. No `finished` pulse follows, and `y` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request; acted on when released |
| x_in | input | WIDTH | Signed input word, captured when the request is accepted |
| y | output | 2·WIDTH | Signed filter output, held between computations |
| finished | output | 1 | One-cycle pulse when `y` has been updated |

## Verification
A counter stuck or off by one shows up as a `finished` pulse earlier or later than TAPS+2 edges after release. A wrong walk order or a dropped tap gives a `y` that differs from the reference sum at the very first impulse. A missing product shift shows as a factor of two in the same result. A mis-shifted history or an uncleared accumulator appears in the results that follow: an impulse then lands on the wrong coefficient, or leftovers from earlier samples show up after reset. A state machine that ignores the release rule, or that re-arms during a computation, produces an extra or premature `finished` pulse within one computation's length.

// File: rtl/fir_mac_pkg.sv
// Shared definitions for the serial FIR multiply-accumulate.
// Assumes: coefficients are formed at elaboration time from integer parameters.
package fir_mac_pkg;

    // Controller states; any other encoding is treated as idle.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_EXEC = 2'd2
    } fir_state_e;

    // Coefficient of tap idx: a linear ramp centred on zero.
    function automatic logic signed [31:0] coef_val(input int idx, input int taps, input int step);
        return 32'(step * (idx + 1) - (step * taps) / 2);
    endfunction

endpackage

// File: rtl/fir_delay_line.sv
// Tap history: TAPS signed words, position 0 holds the newest.
// Assumes: shift_en is a single-cycle strobe per accepted sample; sel < TAPS.
module fir_delay_line #(
    parameter int WIDTH = 16,
    parameter int TAPS  = 8,
    localparam int SEL_W = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift_en,
    input  logic signed [WIDTH-1:0] din,
    input  logic [SEL_W-1:0]        sel,
    output logic signed [WIDTH-1:0] dout
);

    logic signed [WIDTH-1:0] line_q [TAPS];

    for (genvar i = 0; i < TAPS; i++) begin : g_stage
        if (i == 0) begin : g_head
            // Newest word enters position 0 on a shift.
            always_ff @(posedge clk) begin
                if (!rst_n)        line_q[0] <= '0;
                else if (shift_en) line_q[0] <= din;
            end
        end else begin : g_body
            // Older words move one position up on a shift.
            always_ff @(posedge clk) begin
                if (!rst_n)        line_q[i] <= '0;
                else if (shift_en) line_q[i] <= line_q[i-1];
            end
        end
    end

    // Read port for the tap currently being processed.
    assign dout = line_q[sel];

    assert_shift_in_R9: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (line_q[0] == $past(din)));

endmodule

// File: rtl/fir_mac_ctrl.sv
// Sequencer: waits for a released request, loads the history, then walks
// the tap counter from TAPS-1 down to 0 and pulses finished.
// Assumes: start is synchronous to clk.
module fir_mac_ctrl #(
    parameter int TAPS = 8,
    localparam int SEL_W = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             shift_en,
    output logic [SEL_W-1:0] tap_idx,
    output logic             first_step,
    output logic             last_step,
    output logic             step_en,
    output logic             finished
);
    import fir_mac_pkg::*;

    localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(TAPS - 1);

    fir_state_e       state_q;
    logic             armed_q;
    logic [SEL_W-1:0] cnt_q;
    logic             fin_q;

    // State, arm flag, tap counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            armed_q <= 1'b0;
            cnt_q   <= LAST_IDX;
            fin_q   <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        armed_q <= 1'b1;
                    end else if (armed_q) begin
                        armed_q <= 1'b0;
                        state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: state_q <= ST_EXEC;
                ST_EXEC: begin
                    if (cnt_q == '0) begin
                        cnt_q   <= LAST_IDX;
                        fin_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    armed_q <= 1'b0;
                    cnt_q   <= LAST_IDX;
                end
            endcase
        end
    end

    // Strobes decoded from the current state and counter.
    always_comb begin
        shift_en   = (state_q == ST_LOAD);
        step_en    = (state_q == ST_EXEC);
        first_step = step_en && (cnt_q == LAST_IDX);
        last_step  = step_en && (cnt_q == '0);
    end

    assign tap_idx  = cnt_q;
    assign finished = fin_q;

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> (state_q == ST_IDLE));
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_IDX);
    assert_cnt_exec_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_EXEC) |=> $stable(cnt_q));
    assert_fin_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |=> !fin_q);

endmodule

// File: rtl/fir_mac_datapath.sv
// Shared multiplier, fractional shift, single accumulator and output register.
// Assumes: first_step and last_step are only high together with step_en.
module fir_mac_datapath #(
    parameter int WIDTH  = 16,
    parameter int TAPS   = 8,
    parameter int C_STEP = 1000,
    localparam int SEL_W = (TAPS > 1) ? $clog2(TAPS) : 1,
    localparam int ACC_W = 2 * WIDTH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [WIDTH-1:0] sample,
    input  logic [SEL_W-1:0]        tap_idx,
    input  logic                    step_en,
    input  logic                    first_step,
    input  logic                    last_step,
    output logic signed [ACC_W-1:0] y_o
);
    import fir_mac_pkg::*;

    logic signed [WIDTH-1:0] coef_w [TAPS];

    for (genvar i = 0; i < TAPS; i++) begin : g_coef
        localparam logic signed [31:0] CV = coef_val(i, TAPS, C_STEP);
        assign coef_w[i] = CV[WIDTH-1:0];
    end

    logic signed [WIDTH-1:0] coef_sel;
    logic signed [ACC_W-1:0] sample_x, coef_x, prod, prod_fix, acc_next;
    logic signed [ACC_W-1:0] acc_q, y_q;

    // One product per cycle, realigned for fractional format, then summed.
    always_comb begin
        coef_sel = coef_w[tap_idx];
        sample_x = $signed({{WIDTH{sample[WIDTH-1]}}, sample});
        coef_x   = $signed({{WIDTH{coef_sel[WIDTH-1]}}, coef_sel});
        prod     = sample_x * coef_x;
        prod_fix = prod << 1;
        acc_next = first_step ? prod_fix : acc_q + prod_fix;
    end

    // Accumulator register and held output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            y_q   <= '0;
        end else if (step_en) begin
            acc_q <= acc_next;
            if (last_step) y_q <= acc_next;
        end
    end

    assign y_o = y_q;

    assert_y_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !last_step |=> $stable(y_q));

endmodule

// File: rtl/fir_serial_mac.sv
// Serial N-tap FIR: one multiplier, one accumulator, one tap per clock.
// Assumes: start is synchronous; a new request is raised only in idle.
module fir_serial_mac #(
    parameter int WIDTH  = 16,
    parameter int TAPS   = 8,
    parameter int C_STEP = 1000,
    localparam int SEL_W = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic signed [WIDTH-1:0]   x_in,
    output logic signed [2*WIDTH-1:0] y,
    output logic                      finished
);

    logic             shift_en, step_en, first_step, last_step;
    logic [SEL_W-1:0] tap_idx;
    logic signed [WIDTH-1:0] tap_word;

    fir_mac_ctrl #(.TAPS(TAPS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .shift_en(shift_en), .tap_idx(tap_idx),
        .first_step(first_step), .last_step(last_step),
        .step_en(step_en), .finished(finished)
    );

    fir_delay_line #(.WIDTH(WIDTH), .TAPS(TAPS)) u_line (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
        .din(x_in), .sel(tap_idx), .dout(tap_word)
    );

    fir_mac_datapath #(.WIDTH(WIDTH), .TAPS(TAPS), .C_STEP(C_STEP)) u_dp (
        .clk(clk), .rst_n(rst_n), .sample(tap_word), .tap_idx(tap_idx),
        .step_en(step_en), .first_step(first_step), .last_step(last_step),
        .y_o(y)
    );

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (y == '0 && !finished));
    assert_reset_abandon_R10: assert property (@(posedge clk)
        !rst_n |=> !finished);

endmodule

// File: tb/fir_serial_mac_test.sv
`timescale 1ns/1ps
module fir_serial_mac_test;
    localparam int W    = 16;
    localparam int N    = 8;
    localparam int STEP = 1000;
    localparam int YW   = 2 * W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [W-1:0]  x_in = '0;
    logic signed [YW-1:0] y;
    logic finished;

    fir_serial_mac #(.WIDTH(W), .TAPS(N), .C_STEP(STEP)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
        .y(y), .finished(finished)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic signed [YW-1:0] exp_q[$];
    longint hist[N];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R2 coefficient ramp
    function automatic longint coef(input int i);
        return longint'(STEP * (i + 1) - (STEP * N) / 2);
    endfunction

    // R3/R9 reference: shift history, sum shifted products modulo 2^YW
    function automatic logic signed [YW-1:0] push_ref(input longint x);
        longint acc = 0;
        for (int i = N - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        for (int i = 0; i < N; i++) acc += (hist[i] * coef(i)) * 2;
        return acc[YW-1:0];
    endfunction

    // Monitor: scoreboard compare and pulse width check
    bit prev_fin = 1'b0;
    always @(negedge clk) begin
        if (rst_n && finished) begin
            if (exp_q.size() == 0) chk(1'b0, "R8 unexpected finished", 1, 0);
            else begin
                logic signed [YW-1:0] e;
                e = exp_q.pop_front();
                chk(y == e, "R3 y value", longint'(y), longint'(e));
            end
        end
        if (prev_fin && finished) chk(1'b0, "R6 finished longer than one cycle", 1, 0);
        prev_fin = finished;
    end

    // Driver: one request, hold start 'hold' cycles, optional glitch during run
    task automatic run_sample(input logic signed [W-1:0] x, input int hold, input bit glitch);
        int got = 0;
        logic signed [YW-1:0] y_before;
        exp_q.push_back(push_ref(longint'(x)));
        @(negedge clk);
        x_in = x;
        start = 1'b1;
        for (int c = 0; c < hold; c++) begin
            @(negedge clk);
            if (hold > 1) chk(finished == 1'b0, "R4 no finish while start held", finished, 0);
        end
        start = 1'b0;
        y_before = y;
        for (int c = 1; c <= N + 8; c++) begin
            @(negedge clk);
            if (glitch && c == 3) start = 1'b1;
            if (glitch && c == 4) start = 1'b0;
            if (finished) begin got = c; break; end
            if (c < N + 2 && y != y_before) chk(1'b0, "R7 y changed early", longint'(y), longint'(y_before));
        end
        chk(got == N + 2, "R5 latency", got, N + 2);
    endtask

    initial begin
        for (int i = 0; i < N; i++) hist[i] = 0;
        repeat (3) @(negedge clk);
        chk(y == '0, "R1 y after reset", longint'(y), 0);
        chk(finished == 1'b0, "R1 finished after reset", finished, 0);
        rst_n = 1'b1;

        // R9 impulse walks through every tap
        run_sample(16'sh4000, 1, 1'b0);
        for (int k = 0; k < N; k++) run_sample('0, 1 + (k % 3), 1'b0);

        // R4 step input with long start holds
        for (int k = 0; k < N + 2; k++) run_sample(16'sh4000, 5, 1'b0);

        // R7 y holds while idle
        begin
            logic signed [YW-1:0] yh;
            yh = y;
            repeat (12) @(negedge clk);
            chk(y == yh, "R7 y held in idle", longint'(y), longint'(yh));
        end

        // R8 start pulse during a computation is ignored
        run_sample(16'sh1234, 1, 1'b1);
        begin
            logic signed [YW-1:0] yh;
            yh = y;
            repeat (3 * N) @(negedge clk);
            chk(y == yh, "R8 y unchanged after ignored start", longint'(y), longint'(yh));
            chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
        end

        // R3 extreme values (wrap) and random words
        run_sample(16'sh8000, 1, 1'b0);
        run_sample(16'sh7fff, 2, 1'b0);
        run_sample(16'sh8000, 1, 1'b0);
        for (int k = 0; k < 20; k++) run_sample(W'($urandom), 1 + (k % 4), 1'b0);

        // R10 reset in the middle of a computation
        @(negedge clk);
        x_in = 16'sh2000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(y == '0, "R10 y cleared by reset", longint'(y), 0);
        chk(finished == 1'b0, "R10 no finish under reset", finished, 0);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) hist[i] = 0;
        repeat (2 * N) @(negedge clk);
        chk(exp_q.size() == 0, "R10 abandoned run produced nothing", exp_q.size(), 0);

        // R1 history cleared: a lone sample sees only its own tap
        run_sample(16'sh0100, 1, 1'b0);
        run_sample(16'sh0000, 1, 1'b0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule